// File: doc/BRIEF.md
# PWM Auto-Shutdown Controller

This block sits between a PWM waveform generator and the four output pins of a bridge driver (pins A, B, C and D). It watches a set of active-low external fault inputs. Each of them passes through a synchronizer and can be enabled as a trigger by its own select bit. When an enabled fault is seen, the active pins are forced at once into programmed safe states, and a shutdown status flag is raised.

The A/C pair and the B/D pair each have a 2-bit safe-state code. A code can drive the pin low, drive it high, or release it (output enable deasserted). Software clears the status flag with a one-cycle clear request. That request is refused while an enabled fault is still present. After the flag clears, the pins stay in their safe states until the next PWM period boundary, and normal PWM drive resumes there. Pins that the current PWM mode does not use are never driven.

Top module: `pwm_shutdown_ctrl`

## Requirements
- R1: After reset the status flag is 0 and every active pin carries its PWM input with its output enable set.
- R2: An enabled fault input held low forces the active pins to their safe states on the second rising clock edge after it falls. The status flag rises one edge later.
- R3: A fault input whose select bit is 0 has no effect on the pins or on the flag.
- R4: Once set, the status flag stays set, and the pins stay forced, until a clear request is accepted.
- R5: The A/C safe code applies to pins A (bit 0) and C (bit 2). Code 00 drives the pin low and code 01 drives it high, both with the output enable set.
- R6: The B/D safe code applies to pins B (bit 1) and D (bit 3), with the same encoding as R5.
- R7: A safe code of 10 or 11 deasserts the output enable of its pins and drives the pin value 0.
- R8: A pin whose bit in the active-pin mask is 0 always has output enable 0 and value 0, whether or not shutdown is in force.
- R9: A clear request made while an enabled fault is still seen after synchronization is ignored, and the flag stays 1.
- R10: An accepted clear request drops the flag on the next edge. The pins stay forced until a period boundary.
- R11: The pins return to PWM drive on the edge that samples a period-start pulse while the flag is already 0 and no enabled fault is seen. A period start in the same cycle as the clear does not release them.
- R12: While no shutdown is in force, each active pin outputs its PWM input unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_n_i | input | N_FAULT | External fault inputs, active low, asynchronous |
| src_en_i | input | N_FAULT | Per-input enable as a shutdown trigger |
| safe_ac_i | input | 2 | Safe-state code for pins A and C |
| safe_bd_i | input | 2 | Safe-state code for pins B and D |
| pin_active_i | input | 4 | Pins used by the current PWM mode (bit 0 = A .. bit 3 = D) |
| pwm_i | input | 4 | PWM waveforms from the generator |
| period_start_i | input | 1 | One-cycle pulse at the start of each PWM period |
| clr_req_i | input | 1 | One-cycle software request to clear the status flag |
| pin_o | output | 4 | Pin output values |
| pin_oe_o | output | 4 | Pin output enables |
| sd_flag_o | output | 1 | Shutdown status flag |
| sd_active_o | output | 1 | Pins are currently held in safe states |

## Verification
A fault driven between edges reaches the pins on the second following rising edge because of the two synchronizer stages. The flag needs one more edge, so the bench samples the pins after two edges and the flag after three. It also checks that the pins are unchanged after only one edge. Clear and period-start pulses take effect on the single edge that samples them, so each of those checks is made at the falling edge right after that rising edge. All stimulus is applied at falling edges, which keeps every sample half a cycle away from the edge that produced it.

// File: rtl/pwm_sd_pkg.sv
package pwm_sd_pkg;
   localparam int NUM_PINS = 4;
   localparam int PIN_A = 0;
   localparam int PIN_B = 1;
   localparam int PIN_C = 2;
   localparam int PIN_D = 3;

   typedef enum logic [1:0] {
      SAFE_LOW  = 2'b00,
      SAFE_HIGH = 2'b01,
      SAFE_REL0 = 2'b10,
      SAFE_REL1 = 2'b11
   } safe_code_t;

   typedef struct packed {
      logic val;
      logic oe;
   } pin_drive_t;

   function automatic pin_drive_t safe_drive(input safe_code_t code);
      pin_drive_t d;
      case (code)
         SAFE_LOW:  d = '{val: 1'b0, oe: 1'b1};
         SAFE_HIGH: d = '{val: 1'b1, oe: 1'b1};
         default:   d = '{val: 1'b0, oe: 1'b0};
      endcase
      return d;
   endfunction
endpackage

// File: rtl/psd_sync.sv
module psd_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= {WIDTH{RST_VAL}};
      else        chain_q[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= {WIDTH{RST_VAL}};
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/psd_fault_detect.sv
module psd_fault_detect #(
   parameter int N_FAULT = 3
) (
   input  logic [N_FAULT-1:0] fault_sync_n_i,
   input  logic [N_FAULT-1:0] src_en_i,
   output logic               fault_seen_o
);
   logic [N_FAULT-1:0] hit;

   for (genvar i = 0; i < N_FAULT; i++) begin : g_src
      assign hit[i] = src_en_i[i] & ~fault_sync_n_i[i];
   end

   assign fault_seen_o = |hit;
endmodule

// File: rtl/psd_state.sv
module psd_state (
   input  logic clk,
   input  logic rst_n,
   input  logic fault_seen_i,
   input  logic clr_req_i,
   input  logic period_start_i,
   output logic flag_o,
   output logic forced_o
);
   logic flag_q;
   logic hold_q;
   logic clr_ok;
   logic release_ok;

   assign clr_ok     = clr_req_i & ~fault_seen_i;
   assign release_ok = period_start_i & ~flag_q & ~fault_seen_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            flag_q <= 1'b0;
      else if (fault_seen_i) flag_q <= 1'b1;
      else if (clr_ok)       flag_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            hold_q <= 1'b0;
      else if (fault_seen_i) hold_q <= 1'b1;
      else if (release_ok)   hold_q <= 1'b0;
   end

   assign flag_o   = flag_q;
   assign forced_o = fault_seen_i | flag_q | hold_q;
endmodule

// File: rtl/psd_pin_drive.sv
module psd_pin_drive
   import pwm_sd_pkg::*;
(
   input  logic                forced_i,
   input  logic [1:0]          safe_ac_i,
   input  logic [1:0]          safe_bd_i,
   input  logic [NUM_PINS-1:0] pin_active_i,
   input  logic [NUM_PINS-1:0] pwm_i,
   output logic [NUM_PINS-1:0] pin_o,
   output logic [NUM_PINS-1:0] pin_oe_o
);
   pin_drive_t drv_ac;
   pin_drive_t drv_bd;

   assign drv_ac = safe_drive(safe_code_t'(safe_ac_i));
   assign drv_bd = safe_drive(safe_code_t'(safe_bd_i));

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      pin_drive_t safe_p;
      if (p == PIN_A || p == PIN_C) begin : g_ac
         assign safe_p = drv_ac;
      end else begin : g_bd
         assign safe_p = drv_bd;
      end

      always_comb begin
         if (!pin_active_i[p]) begin
            pin_o[p]    = 1'b0;
            pin_oe_o[p] = 1'b0;
         end else if (forced_i) begin
            pin_o[p]    = safe_p.val;
            pin_oe_o[p] = safe_p.oe;
         end else begin
            pin_o[p]    = pwm_i[p];
            pin_oe_o[p] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/pwm_shutdown_ctrl.sv
module pwm_shutdown_ctrl
   import pwm_sd_pkg::*;
#(
   parameter int N_FAULT     = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_FAULT-1:0] fault_n_i,
   input  logic [N_FAULT-1:0] src_en_i,
   input  logic [1:0]         safe_ac_i,
   input  logic [1:0]         safe_bd_i,
   input  logic [3:0]         pin_active_i,
   input  logic [3:0]         pwm_i,
   input  logic               period_start_i,
   input  logic               clr_req_i,
   output logic [3:0]         pin_o,
   output logic [3:0]         pin_oe_o,
   output logic               sd_flag_o,
   output logic               sd_active_o
);
   if (N_FAULT < 1) begin : g_bad_nf
      $error("pwm_shutdown_ctrl: N_FAULT must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pwm_shutdown_ctrl: SYNC_STAGES must be at least 2");
   end
   if (NUM_PINS != 4) begin : g_bad_pins
      $error("pwm_shutdown_ctrl: pin count must be 4");
   end

   logic [N_FAULT-1:0] fault_sync_n;
   logic               fault_seen;
   logic               forced;

   psd_sync #(
      .WIDTH  (N_FAULT),
      .STAGES (SYNC_STAGES),
      .RST_VAL(1'b1)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (fault_n_i),
      .q_o  (fault_sync_n)
   );

   psd_fault_detect #(.N_FAULT(N_FAULT)) u_detect (
      .fault_sync_n_i(fault_sync_n),
      .src_en_i      (src_en_i),
      .fault_seen_o  (fault_seen)
   );

   psd_state u_state (
      .clk           (clk),
      .rst_n         (rst_n),
      .fault_seen_i  (fault_seen),
      .clr_req_i     (clr_req_i),
      .period_start_i(period_start_i),
      .flag_o        (sd_flag_o),
      .forced_o      (forced)
   );

   psd_pin_drive u_drive (
      .forced_i    (forced),
      .safe_ac_i   (safe_ac_i),
      .safe_bd_i   (safe_bd_i),
      .pin_active_i(pin_active_i),
      .pwm_i       (pwm_i),
      .pin_o       (pin_o),
      .pin_oe_o    (pin_oe_o)
   );

   assign sd_active_o = forced;
endmodule

// File: rtl/psd_checker.sv
module psd_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       fault_seen,
   input logic       clr_req_i,
   input logic       period_start_i,
   input logic [3:0] pin_active_i,
   input logic [3:0] pwm_i,
   input logic [3:0] pin_o,
   input logic [3:0] pin_oe_o,
   input logic       sd_flag_o,
   input logic       sd_active_o
);
   // R2
   fault_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_seen |-> sd_active_o);

   // R2
   flag_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_seen |=> sd_flag_o);

   // R4
   flag_holds_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sd_flag_o |-> sd_active_o);

   // R4
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_flag_o && !clr_req_i) |=> sd_flag_o);

   // R9
   clr_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_flag_o && fault_seen && clr_req_i) |=> sd_flag_o);

   // R11
   resume_at_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_active_o && !period_start_i) |=> sd_active_o);

   // R8
   inactive_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_oe_o & ~pin_active_i) == 4'b0) && ((pin_o & ~pin_active_i) == 4'b0));

   // R12
   pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sd_active_o |-> (pin_o == (pwm_i & pin_active_i)) && (pin_oe_o == pin_active_i));
endmodule

bind pwm_shutdown_ctrl psd_checker u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .fault_seen    (fault_seen),
   .clr_req_i     (clr_req_i),
   .period_start_i(period_start_i),
   .pin_active_i  (pin_active_i),
   .pwm_i         (pwm_i),
   .pin_o         (pin_o),
   .pin_oe_o      (pin_oe_o),
   .sd_flag_o     (sd_flag_o),
   .sd_active_o   (sd_active_o)
);

// File: tb/sim_pwm_shutdown_ctrl.sv
module sim_pwm_shutdown_ctrl;
   localparam int NF = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NF-1:0] fault_n_i = '1;
   logic [NF-1:0] src_en_i = '0;
   logic [1:0]    safe_ac_i = 2'b00;
   logic [1:0]    safe_bd_i = 2'b00;
   logic [3:0]    pin_active_i = 4'b1111;
   logic [3:0]    pwm_i = 4'b0000;
   logic          period_start_i = 1'b0;
   logic          clr_req_i = 1'b0;
   logic [3:0]    pin_o;
   logic [3:0]    pin_oe_o;
   logic          sd_flag_o;
   logic          sd_active_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pwm_shutdown_ctrl #(.N_FAULT(NF), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .fault_n_i(fault_n_i), .src_en_i(src_en_i),
      .safe_ac_i(safe_ac_i), .safe_bd_i(safe_bd_i), .pin_active_i(pin_active_i),
      .pwm_i(pwm_i), .period_start_i(period_start_i), .clr_req_i(clr_req_i),
      .pin_o(pin_o), .pin_oe_o(pin_oe_o), .sd_flag_o(sd_flag_o),
      .sd_active_o(sd_active_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic edges(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic pulse_clr;
      clr_req_i = 1'b1;
      edges(1);
      clr_req_i = 1'b0;
   endtask

   task automatic pulse_period;
      period_start_i = 1'b1;
      edges(1);
      period_start_i = 1'b0;
   endtask

   task automatic t_reset;
      pwm_i = 4'b1010;
      edges(1);
      chk("R1", "flag", {3'b0, sd_flag_o}, 4'b0000);
      chk("R1", "pins", pin_o, 4'b1010);
      chk("R1", "oe", pin_oe_o, 4'b1111);
   endtask

   task automatic t_pass;
      pwm_i = 4'b0101;
      edges(1);
      chk("R12", "pins", pin_o, 4'b0101);
      pwm_i = 4'b1100;
      edges(1);
      chk("R12", "pins", pin_o, 4'b1100);
   endtask

   task automatic t_unselected;
      src_en_i = 3'b001;
      pwm_i = 4'b0110;
      fault_n_i = 3'b101;
      edges(4);
      chk("R3", "flag", {3'b0, sd_flag_o}, 4'b0000);
      chk("R3", "pins", pin_o, 4'b0110);
      chk("R3", "oe", pin_oe_o, 4'b1111);
      fault_n_i = 3'b111;
      edges(3);
   endtask

   task automatic t_fault_drive;
      src_en_i = 3'b001;
      safe_ac_i = 2'b01;
      safe_bd_i = 2'b00;
      pwm_i = 4'b1010;
      fault_n_i = 3'b110;
      edges(1);
      chk("R2", "pins after one edge", pin_o, 4'b1010);
      edges(1);
      chk("R5", "pins A/C high", pin_o & 4'b0101, 4'b0101);
      chk("R6", "pins B/D low", pin_o & 4'b1010, 4'b0000);
      chk("R2", "oe", pin_oe_o, 4'b1111);
      chk("R2", "flag not yet", {3'b0, sd_flag_o}, 4'b0000);
      edges(1);
      chk("R2", "flag", {3'b0, sd_flag_o}, 4'b0001);
      pulse_clr;
      chk("R9", "flag kept", {3'b0, sd_flag_o}, 4'b0001);
      fault_n_i = 3'b111;
      edges(4);
      chk("R4", "flag sticky", {3'b0, sd_flag_o}, 4'b0001);
      chk("R4", "pins still forced", pin_o, 4'b0101);
      safe_ac_i = 2'b00;
      safe_bd_i = 2'b01;
      edges(1);
      chk("R6", "B/D high A/C low", pin_o, 4'b1010);
      pwm_i = 4'b0101;
      pulse_clr;
      chk("R10", "flag cleared", {3'b0, sd_flag_o}, 4'b0000);
      chk("R10", "pins forced", pin_o, 4'b1010);
      edges(2);
      chk("R10", "pins forced wait", pin_o, 4'b1010);
      pulse_period;
      chk("R11", "resumed", pin_o, 4'b0101);
      chk("R11", "active", {3'b0, sd_active_o}, 4'b0000);
   endtask

   task automatic t_release_inactive;
      pin_active_i = 4'b0011;
      pwm_i = 4'b1111;
      src_en_i = 3'b100;
      safe_ac_i = 2'b10;
      safe_bd_i = 2'b11;
      edges(1);
      chk("R8", "pins masked", pin_o, 4'b0011);
      chk("R8", "oe masked", pin_oe_o, 4'b0011);
      fault_n_i = 3'b011;
      edges(2);
      chk("R7", "oe released", pin_oe_o, 4'b0000);
      chk("R7", "pins zero", pin_o, 4'b0000);
      fault_n_i = 3'b111;
      edges(3);
      clr_req_i = 1'b1;
      period_start_i = 1'b1;
      edges(1);
      clr_req_i = 1'b0;
      period_start_i = 1'b0;
      chk("R10", "flag cleared", {3'b0, sd_flag_o}, 4'b0000);
      chk("R11", "same-cycle period no release", {3'b0, sd_active_o}, 4'b0001);
      pulse_period;
      chk("R11", "released", pin_oe_o, 4'b0011);
      chk("R8", "C/D still off", pin_oe_o & 4'b1100, 4'b0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_pass;
      t_unselected;
      t_fault_drive;
      t_release_inactive;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule